// File: doc/BRIEF.md
# Protected System Register Access Gate

This block decides what happens when software tries to read or write one guarded system register. Each request arrives as a single-cycle pulse with the requester's privilege level (0 to 3), the access direction and a set of configuration inputs. These inputs are:

- whether the core is halted for debug and whether secure debug is disabled;
- whether levels 2 and 3 are present or enabled;
- the level-3 access enable;
- the fine-grained trap feature flag and its level-3 enable;
- separate read and write fine-grained permission bits.

An ordered chain of checks picks one of four outcomes. The access is either allowed, rejected as an undefined instruction, trapped to level 2 or trapped to level 3. The outcome and an exception class code appear one cycle later, together with a valid strobe. The block does not perform the register access itself.

The chain runs in a fixed order. Level 0 is always rejected and level 3 is always allowed. For levels 1 and 2 the chain checks four conditions in turn:

1. An optional halt-state rejection, enabled by parameter.
2. Level 1 only: the fine-grained level-3 enable.
3. Level 1 only: the direction-specific fine-grained bit.
4. The level-3 access enable.

If none of them fires, the access is allowed.

The output stage is a two-state machine. `RS_IDLE` means no response is shown. `RS_SHOW` means a response is presented for exactly one cycle. The transition `IDLE->SHOW` and the self-loop `SHOW->SHOW` are taken whenever a request pulse is present. The transitions `SHOW->IDLE` and `IDLE->IDLE` are taken when no request is present.

Top module: `sysreg_access_gate`

## Requirements
- R1: A request from level 0 (`req_lvl`=0) always yields outcome 01 (undefined instruction), whatever the other inputs are.
- R2: A request from level 3 (`req_lvl`=3) always yields outcome 00 (allow), whatever the other inputs are.
- R3: When parameter `PRIO_HALT_UNDEF` is 1, a request from level 1 or 2 yields 01 ahead of every other check if all of these hold: `dbg_halted`=1, `sec_dbg_off`=1, `lvl3_present`=1 and `lvl3_access_en`=0.
- R4: At level 1, if no earlier check fired, the outcome is 10 (trap to level 2) when `lvl2_enabled`, `fg_present` and `lvl3_present` are all 1 and `fg_lvl3_en` is 0.
- R5: At level 1, if no earlier check fired, the outcome is 10 when `lvl2_enabled` and `fg_present` are both 1 and the direction's permission bit is 0. A read (`req_write`=0) uses `fg_rd_ok` and a write uses `fg_wr_ok`; the other direction's bit has no effect.
- R6: At level 1 or 2, if no earlier check fired, and `lvl3_present`=1 with `lvl3_access_en`=0, the outcome is 01 when `dbg_halted`=1 and `sec_dbg_off`=1 are both set, and 11 (trap to level 3) otherwise.
- R7: Level 2 never evaluates the fine-grained checks, so it never yields 10. At level 1 or 2, when no check fires, the outcome is 00.
- R8: The outcome is 2 bits (00 allow, 01 undefined, 10 trap to level 2, 11 trap to level 3). It appears on `resp_kind` in the cycle after a `req_valid` pulse, with `resp_valid` high for exactly that cycle. Without a request, `resp_kind` and `resp_class` hold their values. After reset they read 00 and 0.
- R9: `resp_class` is 0x18 for the outcomes 10 and 11, and 0 for the outcomes 00 and 01.
- R10: When `PRIO_HALT_UNDEF` is 0, the halt-state first check of R3 is skipped, so the fine-grained checks of R4 and R5 can fire for a halted level-1 request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Single-cycle access request pulse |
| req_lvl | input | 2 | Privilege level of the requester |
| req_write | input | 1 | 1 for write, 0 for read |
| dbg_halted | input | 1 | Core is halted in debug state |
| sec_dbg_off | input | 1 | Secure debug disabled |
| lvl3_present | input | 1 | Level 3 is implemented |
| lvl3_access_en | input | 1 | Level-3 control permitting lower-level access |
| lvl2_enabled | input | 1 | Level 2 is enabled in the current state |
| fg_present | input | 1 | Fine-grained trap feature implemented |
| fg_lvl3_en | input | 1 | Level-3 enable for the fine-grained trap controls |
| fg_rd_ok | input | 1 | Fine-grained read permission (0 traps reads) |
| fg_wr_ok | input | 1 | Fine-grained write permission (0 traps writes) |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_kind | output | 2 | Outcome code |
| resp_class | output | 6 | Exception class for trap outcomes |

## Verification
The assertions assume that `req_valid` is a clean level sampled at the clock edge. They also assume that every configuration input is stable in the cycle a request is taken, because the decision is made from those values in that one cycle. The bench drives all inputs on the falling edge, raises `req_valid` for one cycle per request, and changes the configuration only together with a new request. The assertions also assume that a reset is applied before the first request. The bench holds reset for several cycles before sending any request.

// File: rtl/sra_pkg.sv
package sra_pkg;
    localparam int LVL_W = 2;
    localparam int EC_W  = 6;
    localparam logic [EC_W-1:0] TRAP_EC = 6'h18;

    typedef enum logic [1:0] {
        OUT_ALLOW = 2'b00,
        OUT_UNDEF = 2'b01,
        OUT_TRAP2 = 2'b10,
        OUT_TRAP3 = 2'b11
    } outcome_e;

    typedef enum logic [2:0] {
        STEP_NONE,
        STEP_HALT_UNDEF,
        STEP_FG_LVL3,
        STEP_FG_DIR,
        STEP_LVL3_EN
    } step_e;

    typedef enum logic {
        RS_IDLE,
        RS_SHOW
    } resp_state_e;
endpackage

// File: rtl/sra_chain.sv
module sra_chain
    import sra_pkg::*;
#(
    parameter bit PRIO_HALT_UNDEF = 1'b1
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic             is_write,
    input  logic             halted,
    input  logic             sdd,
    input  logic             l3_present,
    input  logic             l3_en,
    input  logic             l2_en,
    input  logic             fg_has,
    input  logic             fg_l3_en,
    input  logic             fg_rd,
    input  logic             fg_wr,
    output outcome_e         kind,
    output step_e            fired
);
    logic halt_sdd;
    logic l3_blocks;
    logic fg_live;
    logic dir_ok;
    logic c_halt, c_fgl3, c_fgdir, c_l3;

    assign halt_sdd  = halted & sdd;
    assign l3_blocks = l3_present & ~l3_en;
    assign fg_live   = l2_en & fg_has;
    assign dir_ok    = is_write ? fg_wr : fg_rd;

    generate
        if (PRIO_HALT_UNDEF) begin : g_prio
            assign c_halt = halt_sdd & l3_blocks;
        end else begin : g_noprio
            assign c_halt = 1'b0;
        end
    endgenerate

    assign c_fgl3  = fg_live & l3_present & ~fg_l3_en;
    assign c_fgdir = fg_live & ~dir_ok;
    assign c_l3    = l3_blocks;

    // Ordered chain: the first condition that holds decides.
    always_comb begin
        kind  = OUT_ALLOW;
        fired = STEP_NONE;
        unique case (lvl)
            2'd0: begin
                kind = OUT_UNDEF;
            end
            2'd1: begin
                if (c_halt) begin
                    kind  = OUT_UNDEF;
                    fired = STEP_HALT_UNDEF;
                end else if (c_fgl3) begin
                    kind  = OUT_TRAP2;
                    fired = STEP_FG_LVL3;
                end else if (c_fgdir) begin
                    kind  = OUT_TRAP2;
                    fired = STEP_FG_DIR;
                end else if (c_l3) begin
                    kind  = halt_sdd ? OUT_UNDEF : OUT_TRAP3;
                    fired = STEP_LVL3_EN;
                end
            end
            2'd2: begin
                if (c_halt) begin
                    kind  = OUT_UNDEF;
                    fired = STEP_HALT_UNDEF;
                end else if (c_l3) begin
                    kind  = halt_sdd ? OUT_UNDEF : OUT_TRAP3;
                    fired = STEP_LVL3_EN;
                end
            end
            default: begin
                kind = OUT_ALLOW;
            end
        endcase
    end

    // A level-2 request must never reach a fine-grained step. (R7)
    always_comb begin
        if (lvl == 2'd2) begin
            AST_L2_NO_FG_STEP: assert (fired != STEP_FG_LVL3 && fired != STEP_FG_DIR); // R7
        end
    end
endmodule

// File: rtl/sra_resp_fsm.sv
module sra_resp_fsm
    import sra_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  outcome_e        kind_in,
    output logic            resp_valid,
    output logic [1:0]      resp_kind,
    output logic [EC_W-1:0] resp_class
);
    resp_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            RS_IDLE: state_d = req_valid ? RS_SHOW : RS_IDLE;
            RS_SHOW: state_d = req_valid ? RS_SHOW : RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_kind  <= OUT_ALLOW;
            resp_class <= '0;
        end else if (req_valid) begin
            resp_kind <= kind_in;
            unique case (kind_in)
                OUT_TRAP2, OUT_TRAP3: resp_class <= TRAP_EC;
                default:              resp_class <= '0;
            endcase
        end
    end

    assign resp_valid = (state_q == RS_SHOW);

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R8
    AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R8
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(resp_kind) && $stable(resp_class)); // R8
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_kind[1] |-> resp_class == TRAP_EC); // R9
    AST_NOTRAP_CLASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_kind[1] |-> resp_class == '0); // R9
endmodule

// File: rtl/sysreg_access_gate.sv
module sysreg_access_gate
    import sra_pkg::*;
#(
    parameter bit PRIO_HALT_UNDEF = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_lvl,
    input  logic       req_write,
    input  logic       dbg_halted,
    input  logic       sec_dbg_off,
    input  logic       lvl3_present,
    input  logic       lvl3_access_en,
    input  logic       lvl2_enabled,
    input  logic       fg_present,
    input  logic       fg_lvl3_en,
    input  logic       fg_rd_ok,
    input  logic       fg_wr_ok,
    output logic       resp_valid,
    output logic [1:0] resp_kind,
    output logic [5:0] resp_class
);
    outcome_e decided;
    step_e    step_hit;

    sra_chain #(.PRIO_HALT_UNDEF(PRIO_HALT_UNDEF)) u_chain (
        .lvl        (req_lvl),
        .is_write   (req_write),
        .halted     (dbg_halted),
        .sdd        (sec_dbg_off),
        .l3_present (lvl3_present),
        .l3_en      (lvl3_access_en),
        .l2_en      (lvl2_enabled),
        .fg_has     (fg_present),
        .fg_l3_en   (fg_lvl3_en),
        .fg_rd      (fg_rd_ok),
        .fg_wr      (fg_wr_ok),
        .kind       (decided),
        .fired      (step_hit)
    );

    sra_resp_fsm u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .kind_in    (decided),
        .resp_valid (resp_valid),
        .resp_kind  (resp_kind),
        .resp_class (resp_class)
    );

    AST_LVL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_lvl == 2'd0 |=> resp_kind == 2'b01); // R1
    AST_LVL3_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_lvl == 2'd3 |=> resp_kind == 2'b00); // R2
    AST_LVL2_NEVER_TRAP2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_lvl == 2'd2 |=> resp_kind != 2'b10); // R7
    AST_HALT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && PRIO_HALT_UNDEF && req_lvl inside {2'd1, 2'd2} && dbg_halted
        && sec_dbg_off && lvl3_present && !lvl3_access_en |=> resp_kind == 2'b01); // R3
    AST_STEP_MATCHES_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && step_hit == STEP_NONE && req_lvl != 2'd0 |=> resp_kind == 2'b00); // R7
endmodule

// File: tb/sysreg_access_gate_bench.sv
module sysreg_access_gate_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_lvl = '0;
    logic req_write = 1'b0, dbg_halted = 1'b0, sec_dbg_off = 1'b0;
    logic lvl3_present = 1'b0, lvl3_access_en = 1'b0, lvl2_enabled = 1'b0;
    logic fg_present = 1'b0, fg_lvl3_en = 1'b0, fg_rd_ok = 1'b0, fg_wr_ok = 1'b0;
    logic       resp_valid, np_valid;
    logic [1:0] resp_kind, np_kind;
    logic [5:0] resp_class, np_class;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sysreg_access_gate u_sysreg_access_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lvl(req_lvl),
        .req_write(req_write), .dbg_halted(dbg_halted), .sec_dbg_off(sec_dbg_off),
        .lvl3_present(lvl3_present), .lvl3_access_en(lvl3_access_en),
        .lvl2_enabled(lvl2_enabled), .fg_present(fg_present), .fg_lvl3_en(fg_lvl3_en),
        .fg_rd_ok(fg_rd_ok), .fg_wr_ok(fg_wr_ok),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_class(resp_class)
    );

    sysreg_access_gate #(.PRIO_HALT_UNDEF(1'b0)) u_noprio (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lvl(req_lvl),
        .req_write(req_write), .dbg_halted(dbg_halted), .sec_dbg_off(sec_dbg_off),
        .lvl3_present(lvl3_present), .lvl3_access_en(lvl3_access_en),
        .lvl2_enabled(lvl2_enabled), .fg_present(fg_present), .fg_lvl3_en(fg_lvl3_en),
        .fg_rd_ok(fg_rd_ok), .fg_wr_ok(fg_wr_ok),
        .resp_valid(np_valid), .resp_kind(np_kind), .resp_class(np_class)
    );

    // {lvl[1:0], wr, halted, sdd, l3pres, l3en, l2en, fg, fgl3, rd_ok, wr_ok, expected[1:0]}
    localparam int NV = 18;
    localparam logic [13:0] VEC [NV] = '{
        14'b00_0_0_0_1_1_1_1_1_1_1_01, // R1
        14'b00_1_1_1_0_0_0_0_0_0_0_01, // R1
        14'b11_0_1_1_1_0_1_1_0_0_0_00, // R2
        14'b01_0_0_0_1_1_1_1_1_1_1_00, // R7
        14'b01_0_1_1_1_0_1_1_0_0_0_01, // R3
        14'b01_0_0_0_1_1_1_1_0_1_1_10, // R4
        14'b01_0_0_0_1_1_1_1_1_0_1_10, // R5 read denied
        14'b01_0_0_0_1_1_1_1_1_1_0_00, // R5 read ignores write bit
        14'b01_1_0_0_1_1_1_1_1_1_0_10, // R5 write denied
        14'b01_1_0_0_1_1_1_1_1_0_1_00, // R5 write ignores read bit
        14'b01_0_0_0_1_0_1_0_0_0_0_11, // R6
        14'b01_0_1_0_1_0_0_1_0_0_0_11, // R6 halted without sdd
        14'b01_0_1_1_0_0_0_1_0_0_0_00, // R7 no level 3
        14'b10_0_0_0_1_1_1_1_0_0_0_00, // R7 level 2 skips fine-grained
        14'b10_1_0_0_1_0_1_1_0_0_0_11, // R6 level 2
        14'b10_0_1_1_1_0_0_0_0_0_0_01, // R3 level 2
        14'b01_0_1_0_1_0_1_1_1_1_1_11, // R6 halted, sdd clear
        14'b11_1_0_0_1_0_1_1_0_0_0_00  // R2 write
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [13:0] v);
        @(negedge clk);
        {req_lvl, req_write, dbg_halted, sec_dbg_off, lvl3_present, lvl3_access_en,
         lvl2_enabled, fg_present, fg_lvl3_en, fg_rd_ok, fg_wr_ok} = v[13:2];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R8 reset valid", resp_valid, 0);
        check("R8 reset kind", resp_kind, 0);
        check("R9 reset class", resp_class, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle valid", resp_valid, 0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check($sformatf("R8 valid vec%0d", i), resp_valid, 1);
            check($sformatf("R1-R7 kind vec%0d", i), resp_kind, VEC[i][1:0]);
            check($sformatf("R9 class vec%0d", i), resp_class, VEC[i][1] ? 6'h18 : 6'h00);
        end

        // R8: hold after the one-cycle strobe, with inputs changed meanwhile
        apply(14'b01_0_0_0_1_0_1_0_0_0_0_11);
        req_lvl = 2'd0;
        @(negedge clk);
        check("R8 strobe drops", resp_valid, 0);
        check("R8 kind held", resp_kind, 2'b11);
        check("R9 class held", resp_class, 6'h18);

        // R10: halted level-1 request, halt priority disabled -> fine-grained trap
        apply(14'b01_0_1_1_1_0_1_1_0_0_0_01);
        check("R10 prio instance", resp_kind, 2'b01);
        check("R10 no-prio instance", np_kind, 2'b10);
        check("R10 no-prio class", np_class, 6'h18);
        // R10: with no fine-grained hit, the level-3 check still rejects
        apply(14'b10_0_1_1_1_0_0_0_0_0_0_01);
        check("R10 no-prio level 2 undef", np_kind, 2'b01);

        // R8: back-to-back requests keep the strobe high
        @(negedge clk);
        {req_lvl, req_write} = {2'd0, 1'b0};
        req_valid = 1'b1;
        @(negedge clk);
        check("R8 b2b first", resp_kind, 2'b01);
        req_lvl = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 b2b valid", resp_valid, 1);
        check("R2 b2b kind", resp_kind, 2'b00);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule